// File: doc/BRIEF.md
# Instruction Release Gate with Push-Button Confirmation

This block stands between the instruction fetch controller and the instruction decoder of a small processor and decides when each fetched instruction may execute. The fetch controller presents a 13-bit word together with a ready flag. The low 12 bits are a 4-bit opcode in bits 11:8 and an 8-bit operand in bits 7:0. Bit 12 is a per-instruction confirmation flag. The gate takes the word in, acknowledges it, and then releases it to the decoder. Release happens at once when the flag is 0. When the flag is 1, release waits until the operator has let go of a push button.

The gate has three states: `ST_IDLE` (waiting for a word), `ST_WAIT` (a flagged word is held and the decoder is starved), and `ST_ISSUE` (a single cycle in which the word goes to the decoder and the program counter advances). Its transitions are:
- **accept-plain**: `ST_IDLE` to `ST_ISSUE` when ready is high and the flag is 0.
- **accept-flagged**: `ST_IDLE` to `ST_WAIT` when ready is high and the flag is 1.
- **confirm**: `ST_WAIT` to `ST_ISSUE` on a falling edge of the synchronized button.
- **retire**: `ST_ISSUE` to `ST_IDLE` unconditionally.

The button input is already debounced. It passes through a two-flop synchronizer and then a falling-edge detector. A button that is still held when the wait begins therefore confirms only once it is released.

Top module: `exec_gate`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `pc_en`, `fetch_ack` and `dec_valid` low, `dec_opcode` 0 and `dec_operand` 0, and the gate is idle.
- R2: When `fetch_rdy` is high at a rising edge in `ST_IDLE`, the word is accepted and `fetch_ack` is high for exactly the following cycle.
- R3: A word with bit 12 equal to 0 is issued in the same cycle its `fetch_ack` is high. In that cycle `pc_en` and `dec_valid` are 1, `dec_opcode` equals word bits 11:8 and `dec_operand` equals word bits 7:0.
- R4: While a word with bit 12 equal to 1 is waiting, `pc_en` and `dec_valid` stay 0 and the decoder sees the no-operation marker: `dec_opcode` 0 and `dec_operand` 0.
- R5: A 1-to-0 change on `btn` during `ST_WAIT` makes `pc_en` high in the cycle after the third rising edge following the change, and low in the cycle after the second.
- R6: Pressing the button (a 0-to-1 change), or holding it, never releases a waiting word.
- R7: If the button is already held when a flagged word is accepted, the word stays waiting until the button is released, and that release confirms it with the R5 latency.
- R8: The word issued after a wait is the one latched at acceptance, whatever `fetch_word` carries during the wait.
- R9: `fetch_rdy` is ignored outside `ST_IDLE`: no `fetch_ack` is raised and the held word is kept.
- R10: A button falling edge detected in the same cycle a flagged word is accepted does not confirm that word.
- R11: `pc_en` is high for exactly one cycle per issued word, and the gate then accepts the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word | input | 13 | Fetched word: bit 12 confirmation flag, bits 11:8 opcode, bits 7:0 operand |
| fetch_rdy | input | 1 | Fetch controller has a word on `fetch_word` |
| btn | input | 1 | Debounced push button, high while pressed, asynchronous |
| dec_opcode | output | 4 | Opcode to the decoder, 0 when nothing is issued |
| dec_operand | output | 8 | Operand to the decoder, 0 when nothing is issued |
| dec_valid | output | 1 | Decoder outputs carry an instruction to execute |
| pc_en | output | 1 | One-cycle program counter enable for the issued instruction |
| fetch_ack | output | 1 | One-cycle acknowledge that the word was taken |

## Verification
Two events can fall in the same cycle: a synchronized button release and the acceptance of a flagged word. The bench provokes this by holding the button, releasing it, and timing `fetch_rdy` so that acceptance lands in exactly the cycle in which the edge detector fires. It then requires `pc_en` to stay low for many cycles afterwards, and only a later press-and-release may issue the word. A second overlap, `fetch_rdy` raised while a word is waiting, is judged by the absence of `fetch_ack` and by the opcode that finally issues.

// File: rtl/exec_gate_pkg.sv
package exec_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2
    } gate_state_t;

endpackage

// File: rtl/exec_gate_btn.sv
module exec_gate_btn #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic btn_fall
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= btn_raw;
        end
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q[g] <= 1'b0;
            end else begin
                sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_prev_q <= 1'b0;
        end else begin
            level_prev_q <= sync_q[LAST];
        end
    end

    assign btn_fall = level_prev_q & ~sync_q[LAST];

    // R5
    fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        btn_fall |=> !btn_fall);

endmodule

// File: rtl/exec_gate_hold.sv
module exec_gate_hold #(
    parameter int OPC_W = 4,
    parameter int OPR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [OPC_W+OPR_W:0]   word_in,
    output logic                   flag_q,
    output logic [OPC_W-1:0]       opc_q,
    output logic [OPR_W-1:0]       opr_q
);

    localparam int FLAG_BIT = OPC_W + OPR_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            opc_q  <= '0;
            opr_q  <= '0;
        end else if (load) begin
            flag_q <= word_in[FLAG_BIT];
            opc_q  <= word_in[FLAG_BIT-1:OPR_W];
            opr_q  <= word_in[OPR_W-1:0];
        end
    end

    // R8
    held_word_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(opc_q) && $stable(opr_q) && $stable(flag_q)));

endmodule

// File: rtl/exec_gate_fsm.sv
module exec_gate_fsm
    import exec_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic word_rdy,
    input  logic word_flag,
    input  logic confirm,
    output logic accept,
    output logic issue,
    output logic ack_q
);

    gate_state_t state_q;
    gate_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (word_rdy) begin
                    state_d = word_flag ? ST_WAIT : ST_ISSUE;
                end
            end
            ST_WAIT: begin
                if (confirm) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= accept;
        end
    end

    always_comb begin
        accept = 1'b0;
        issue  = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept = word_rdy;
            ST_WAIT:  issue  = 1'b0;
            ST_ISSUE: issue  = 1'b1;
            default:  issue  = 1'b0;
        endcase
    end

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    // R9
    ack_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> ($past(state_q) == ST_IDLE));

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !confirm) |=> state_q == ST_WAIT);

    // R11
    issue_once_chk: assert property (@(posedge clk) disable iff (rst)
        issue |=> (!issue && state_q == ST_IDLE));

endmodule

// File: rtl/exec_gate.sv
module exec_gate #(
    parameter int OPC_W       = 4,
    parameter int OPR_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [3:0] NOP_OPC = 4'h0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [OPC_W+OPR_W:0]   fetch_word,
    input  logic                   fetch_rdy,
    input  logic                   btn,
    output logic [OPC_W-1:0]       dec_opcode,
    output logic [OPR_W-1:0]       dec_operand,
    output logic                   dec_valid,
    output logic                   pc_en,
    output logic                   fetch_ack
);

    localparam int FLAG_BIT = OPC_W + OPR_W;

    logic             btn_fall;
    logic             accept;
    logic             issue;
    logic             flag_q;
    logic [OPC_W-1:0] opc_q;
    logic [OPR_W-1:0] opr_q;

    exec_gate_btn #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_btn (
        .clk      (clk),
        .rst      (rst),
        .btn_raw  (btn),
        .btn_fall (btn_fall)
    );

    exec_gate_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .word_rdy  (fetch_rdy),
        .word_flag (fetch_word[FLAG_BIT]),
        .confirm   (btn_fall),
        .accept    (accept),
        .issue     (issue),
        .ack_q     (fetch_ack)
    );

    exec_gate_hold #(
        .OPC_W (OPC_W),
        .OPR_W (OPR_W)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .word_in (fetch_word),
        .flag_q  (flag_q),
        .opc_q   (opc_q),
        .opr_q   (opr_q)
    );

    assign pc_en       = issue;
    assign dec_valid   = issue;
    assign dec_opcode  = issue ? opc_q : NOP_OPC[OPC_W-1:0];
    assign dec_operand = issue ? opr_q : '0;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!pc_en && !fetch_ack && !dec_valid));

    // R3
    plain_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_ack && !flag_q) |-> pc_en);

    // R5
    confirm_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_en && flag_q && !fetch_ack) |-> $past(btn_fall));

    // R10
    no_early_confirm_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_ack && flag_q) |-> !pc_en);

endmodule

// File: tb/exec_gate_tb.sv
module exec_gate_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] fetch_word;
    logic        fetch_rdy;
    logic        btn;
    logic [3:0]  dec_opcode;
    logic [7:0]  dec_operand;
    logic        dec_valid;
    logic        pc_en;
    logic        fetch_ack;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    exec_gate u_dut (
        .clk         (clk),
        .rst         (rst),
        .fetch_word  (fetch_word),
        .fetch_rdy   (fetch_rdy),
        .btn         (btn),
        .dec_opcode  (dec_opcode),
        .dec_operand (dec_operand),
        .dec_valid   (dec_valid),
        .pc_en       (pc_en),
        .fetch_ack   (fetch_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_outputs(input string req);
        chk(pc_en == 1'b0, req, "pc_en", pc_en, 0);
        chk(dec_valid == 1'b0, req, "dec_valid", dec_valid, 0);
        chk(dec_opcode == 4'h0, req, "nop opcode", dec_opcode, 0);
        chk(dec_operand == 8'h00, req, "nop operand", dec_operand, 0);
    endtask

    // presents a word for one accepting edge, returns in the ack cycle
    task automatic offer(input logic [12:0] w);
        fetch_word = w;
        fetch_rdy  = 1'b1;
        step();
        fetch_rdy  = 1'b0;
        chk(fetch_ack == 1'b1, "R2", "ack after accept", fetch_ack, 1);
    endtask

    task automatic expect_issue(input string req, input logic [3:0] op,
                                input logic [7:0] arg);
        chk(pc_en == 1'b1, req, "pc_en at issue", pc_en, 1);
        chk(dec_valid == 1'b1, req, "dec_valid at issue", dec_valid, 1);
        chk(dec_opcode == op, req, "opcode", dec_opcode, op);
        chk(dec_operand == arg, req, "operand", dec_operand, arg);
        step();
        chk(pc_en == 1'b0, "R11", "pc_en drops", pc_en, 0);
        chk(fetch_ack == 1'b0, "R2", "ack one cycle", fetch_ack, 0);
    endtask

    // releases the button and checks the R5 latency
    task automatic release_and_issue(input string req, input logic [3:0] op,
                                     input logic [7:0] arg);
        btn = 1'b0;
        step();
        chk(pc_en == 1'b0, req, "pc_en 1 edge after release", pc_en, 0);
        step();
        chk(pc_en == 1'b0, "R5", "pc_en 2 edges after release", pc_en, 0);
        step();
        expect_issue(req, op, arg);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        fetch_rdy = 1'b0;
        fetch_word = '0;
        btn = 1'b0;
        step();
        step();
        chk(fetch_ack == 1'b0, "R1", "ack in reset", fetch_ack, 0);
        idle_outputs("R1");
        rst = 1'b0;
        step();
        idle_outputs("R1");
    endtask

    task automatic t_plain();
        offer(13'h0_5A3);
        expect_issue("R3", 4'h5, 8'hA3);
        offer(13'h0_F01);
        expect_issue("R11", 4'hF, 8'h01);
    endtask

    task automatic t_flag_press_release();
        offer(13'h1_3C4);
        idle_outputs("R4");
        fetch_word = 13'h0_E77;
        for (int i = 0; i < 6; i++) step();
        idle_outputs("R4");
        btn = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            chk(pc_en == 1'b0, "R6", "press does not release", pc_en, 0);
        end
        release_and_issue("R8", 4'h3, 8'hC4);
    endtask

    task automatic t_held_before();
        btn = 1'b1;
        for (int i = 0; i < 4; i++) step();
        offer(13'h1_72B);
        for (int i = 0; i < 8; i++) begin
            step();
            chk(pc_en == 1'b0, "R7", "held button keeps wait", pc_en, 0);
        end
        release_and_issue("R7", 4'h7, 8'h2B);
    endtask

    task automatic t_busy_rdy();
        offer(13'h1_9D0);
        step();
        fetch_word = 13'h0_411;
        fetch_rdy  = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk(fetch_ack == 1'b0, "R9", "no ack while waiting", fetch_ack, 0);
        end
        fetch_rdy = 1'b0;
        btn = 1'b1;
        for (int i = 0; i < 4; i++) step();
        release_and_issue("R9", 4'h9, 8'hD0);
    endtask

    task automatic t_edge_at_accept();
        btn = 1'b1;
        for (int i = 0; i < 4; i++) step();
        btn = 1'b0;
        step();
        step();
        offer(13'h1_B66);
        for (int i = 0; i < 8; i++) begin
            step();
            chk(pc_en == 1'b0, "R10", "edge at accept ignored", pc_en, 0);
        end
        btn = 1'b1;
        for (int i = 0; i < 4; i++) step();
        release_and_issue("R10", 4'hB, 8'h66);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_plain();
        t_flag_press_release();
        t_held_before();
        t_busy_rdy();
        t_edge_at_accept();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule